// File: doc/BRIEF.md
# Packet Page Allocator with Page Queues

This block keeps track of a small pool of fixed-size packet pages in a network controller. A bitmask records which pages are taken, and three short queues of page numbers record pages waiting to be sent, pages already sent, and pages holding received frames. The packet data itself lives elsewhere; this block only hands out, queues and frees page numbers.

A host writes through a single byte port whose selector picks a command byte, the packet-number register or an interrupt acknowledge. The three upper bits of a command byte select one of eight page operations. A receive engine asks for pages with a request line and gets a grant or a refusal one cycle later. When transmission is enabled, queued pages are retired one per cycle, either freed at once or parked in the sent queue for the host to collect. A transmit allocation that finds no free page stays pending and completes on its own as soon as any page is freed.

Top module: `pkt_page_mgr`

## Requirements
- R1: After reset every page is free (used_count 0), mem_size reads PAGES (4), alloc_result reads 0, pkt_num reads 0, both queue heads read 0x80, int_alloc, int_rcv and int_txdone are low and int_txq_empty is high.
- R2: A host write with host_sel 0 is a command whose code is host_wdata[7:5]; host_sel 1 loads the packet-number register from the low page-index bits; host_sel 2 is an acknowledge in which bit 3 clears int_alloc and bit 1 removes the sent-queue head; host_sel 3 changes nothing.
- R3: Code 1 grants the lowest-numbered free page, marks it taken, puts its number in alloc_result and raises int_alloc; with no free page it leaves alloc_result at 0x80 and int_alloc low.
- R4: While alloc_result holds 0x80, every page release (codes 4 and 5, or an auto-release retirement) at once grants the lowest free page to the pending allocation, updating alloc_result and raising int_alloc.
- R5: Code 2 frees every page, empties all three queues, sets alloc_result to 0 and lowers int_rcv.
- R6: Code 7 empties only the transmit queue and the sent queue; page ownership is unchanged.
- R7: Code 3 removes the receive-queue head and code 4 removes it and frees its page; int_rcv stays high while entries remain and falls when the queue empties; on an empty queue both leave all pages and queues unchanged.
- R8: Code 5 frees the page named by the packet-number register; code 6 appends that page to the transmit queue, and is dropped when the queue already holds PAGES entries.
- R9: While tx_en is high, each cycle with no host write retires the transmit-queue head: with auto_rel high its page is freed, otherwise it is appended to the sent queue (dropped if full). int_txq_empty is high exactly when the transmit queue is empty.
- R10: A receive request served in a cycle takes the lowest free page, appends it to the receive queue and raises int_rcv, with rx_grant and rx_page valid in the following cycle; with no free page rx_fail pulses instead.
- R11: At most one operation runs per cycle, chosen in the order host write, then transmit retirement, then receive request; a receive request that loses simply waits.
- R12: txdone_head and rx_head give the queue head page number, or 0x80 when that queue is empty; int_txdone is high exactly when the sent queue holds an entry; used_count is the number of taken pages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Write target: 0 command, 1 packet number, 2 acknowledge, 3 none |
| host_wdata | input | 8 | Host write byte |
| tx_en | input | 1 | Enables retirement of the transmit queue |
| auto_rel | input | 1 | Free retired pages instead of parking them |
| rx_req | input | 1 | Receive-side page request (held until served) |
| rx_grant | output | 1 | Receive request granted (one-cycle pulse) |
| rx_fail | output | 1 | Receive request refused, no page (one-cycle pulse) |
| rx_page | output | PNW | Page granted to the receive side |
| alloc_result | output | 8 | Transmit allocation result, 0x80 when pending |
| pkt_num | output | 8 | Packet-number register |
| txdone_head | output | 8 | Sent-queue head or 0x80 |
| rx_head | output | 8 | Receive-queue head or 0x80 |
| mem_size | output | 8 | Number of pages in the pool |
| used_count | output | 8 | Number of taken pages |
| int_alloc | output | 1 | Allocation-done flag |
| int_rcv | output | 1 | Receive queue not empty flag |
| int_txdone | output | 1 | Sent queue not empty flag |
| int_txq_empty | output | 1 | Transmit queue empty flag |

## Verification
Two pairs of functions compete for the one operation slot per cycle: a host write against a receive request, and a transmit retirement against a receive request. The bench raises the receive request in the same cycle as a host write, then in the same cycle that tx_en opens a loaded transmit queue, and judges that no grant appears in the contested cycle, that the page count is untouched by the loser, and that the waiting request is granted the next lowest page one cycle later. A release that wakes a pending transmit allocation, through both the release command and an auto-release retirement, is checked the same way at the result register.

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr #(
  parameter int PAGES = 4,
  parameter int PNW   = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_we,
  input  logic [1:0]     host_sel,
  input  logic [7:0]     host_wdata,
  input  logic           tx_en,
  input  logic           auto_rel,
  input  logic           rx_req,
  output logic           rx_grant,
  output logic           rx_fail,
  output logic [PNW-1:0] rx_page,
  output logic [7:0]     alloc_result,
  output logic [7:0]     pkt_num,
  output logic [7:0]     txdone_head,
  output logic [7:0]     rx_head,
  output logic [7:0]     mem_size,
  output logic [7:0]     used_count,
  output logic           int_alloc,
  output logic           int_rcv,
  output logic           int_txdone,
  output logic           int_txq_empty
);

  localparam logic [7:0] NONE = 8'h80;
  localparam int CW = $clog2(PAGES + 1);
  localparam logic [CW-1:0] FULL = CW'(PAGES);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [PAGES-1:0] mask, mask_n;
  logic [PNW-1:0]   txq  [PAGES];
  logic [PNW-1:0]   txq_n[PAGES];
  logic [PNW-1:0]   done  [PAGES];
  logic [PNW-1:0]   done_n[PAGES];
  logic [PNW-1:0]   rxq  [PAGES];
  logic [PNW-1:0]   rxq_n[PAGES];
  logic [CW-1:0]    txq_len, txq_len_n, done_len, done_len_n, rx_len, rx_len_n;
  logic [7:0]       ares, ares_n;
  logic [PNW-1:0]   pnum, pnum_n;
  logic             ialloc, ialloc_n, ircv, ircv_n;
  logic             gnt_q, gnt_n, fail_q, fail_n;
  logic [PNW-1:0]   rpg_q, rpg_n;

  logic             drain, rx_do, rel;
  logic [PNW-1:0]   rel_pg, pg;
  logic [2:0]       code;

  function automatic logic [PNW-1:0] low_free(input logic [PAGES-1:0] m);
    low_free = '0;
    for (int i = PAGES - 1; i >= 0; i--)
      if (!m[i]) low_free = PNW'(i);
  endfunction

  assign code  = host_wdata[7:5];
  assign drain = tx_en && (txq_len != '0) && !host_we;
  assign rx_do = rx_req && !host_we && !drain;

  always_comb begin
    mask_n     = mask;
    txq_n      = txq;
    done_n     = done;
    rxq_n      = rxq;
    txq_len_n  = txq_len;
    done_len_n = done_len;
    rx_len_n   = rx_len;
    ares_n     = ares;
    pnum_n     = pnum;
    ialloc_n   = ialloc;
    ircv_n     = ircv;
    gnt_n      = 1'b0;
    fail_n     = 1'b0;
    rpg_n      = rpg_q;
    rel        = 1'b0;
    rel_pg     = '0;
    pg         = '0;

    if (host_we) begin
      case (host_sel)
        2'd0: begin
          case (code)
            3'd1: begin
              ares_n   = NONE;
              ialloc_n = 1'b0;
              if (!(&mask)) begin
                pg         = low_free(mask);
                mask_n[pg] = 1'b1;
                ares_n     = 8'(pg);
                ialloc_n   = 1'b1;
              end
            end
            3'd2: begin
              mask_n     = '0;
              txq_len_n  = '0;
              done_len_n = '0;
              rx_len_n   = '0;
              ares_n     = '0;
              ircv_n     = 1'b0;
            end
            3'd3, 3'd4: begin
              if (rx_len != '0) begin
                if (code == 3'd4) begin
                  rel    = 1'b1;
                  rel_pg = rxq[0];
                end
                for (int i = 0; i < PAGES - 1; i++) rxq_n[i] = rxq[i+1];
                rx_len_n = rx_len - ONE;
              end
              ircv_n = rx_len > ONE;
            end
            3'd5: begin
              rel    = 1'b1;
              rel_pg = pnum;
            end
            3'd6: begin
              if (txq_len != FULL) begin
                for (int i = 0; i < PAGES; i++)
                  if (CW'(i) == txq_len) txq_n[i] = pnum;
                txq_len_n = txq_len + ONE;
              end
            end
            3'd7: begin
              txq_len_n  = '0;
              done_len_n = '0;
            end
            default: ;
          endcase
        end
        2'd1: pnum_n = host_wdata[PNW-1:0];
        2'd2: begin
          if (host_wdata[3]) ialloc_n = 1'b0;
          if (host_wdata[1] && done_len != '0) begin
            for (int i = 0; i < PAGES - 1; i++) done_n[i] = done[i+1];
            done_len_n = done_len - ONE;
          end
        end
        default: ;
      endcase
    end else if (drain) begin
      for (int i = 0; i < PAGES - 1; i++) txq_n[i] = txq[i+1];
      txq_len_n = txq_len - ONE;
      if (auto_rel) begin
        rel    = 1'b1;
        rel_pg = txq[0];
      end else if (done_len != FULL) begin
        for (int i = 0; i < PAGES; i++)
          if (CW'(i) == done_len) done_n[i] = txq[0];
        done_len_n = done_len + ONE;
      end
    end else if (rx_do) begin
      if (!(&mask) && rx_len != FULL) begin
        pg         = low_free(mask);
        mask_n[pg] = 1'b1;
        for (int i = 0; i < PAGES; i++)
          if (CW'(i) == rx_len) rxq_n[i] = pg;
        rx_len_n = rx_len + ONE;
        ircv_n   = 1'b1;
        gnt_n    = 1'b1;
        rpg_n    = pg;
      end else begin
        fail_n = 1'b1;
      end
    end

    if (rel) begin
      mask_n[rel_pg] = 1'b0;
      if (ares == NONE && !(&mask_n)) begin
        pg         = low_free(mask_n);
        mask_n[pg] = 1'b1;
        ares_n     = 8'(pg);
        ialloc_n   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask     <= '0;
      txq_len  <= '0;
      done_len <= '0;
      rx_len   <= '0;
      ares     <= '0;
      pnum     <= '0;
      ialloc   <= 1'b0;
      ircv     <= 1'b0;
      gnt_q    <= 1'b0;
      fail_q   <= 1'b0;
      rpg_q    <= '0;
      for (int i = 0; i < PAGES; i++) begin
        txq[i]  <= '0;
        done[i] <= '0;
        rxq[i]  <= '0;
      end
    end else begin
      mask     <= mask_n;
      txq      <= txq_n;
      done     <= done_n;
      rxq      <= rxq_n;
      txq_len  <= txq_len_n;
      done_len <= done_len_n;
      rx_len   <= rx_len_n;
      ares     <= ares_n;
      pnum     <= pnum_n;
      ialloc   <= ialloc_n;
      ircv     <= ircv_n;
      gnt_q    <= gnt_n;
      fail_q   <= fail_n;
      rpg_q    <= rpg_n;
    end
  end

  always_comb begin
    used_count = '0;
    for (int i = 0; i < PAGES; i++) used_count = used_count + 8'(mask[i]);
  end

  assign rx_grant      = gnt_q;
  assign rx_fail       = fail_q;
  assign rx_page       = rpg_q;
  assign alloc_result  = ares;
  assign pkt_num       = 8'(pnum);
  assign txdone_head   = (done_len == '0) ? NONE : 8'(done[0]);
  assign rx_head       = (rx_len == '0) ? NONE : 8'(rxq[0]);
  assign mem_size      = 8'(PAGES);
  assign int_alloc     = ialloc;
  assign int_rcv       = ircv;
  assign int_txdone    = done_len != '0;
  assign int_txq_empty = txq_len == '0;

endmodule

// File: rtl/pkt_page_mgr_chk.sv
module pkt_page_mgr_chk #(
  parameter int PAGES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_we,
  input logic       rx_grant,
  input logic       rx_fail,
  input logic [7:0] alloc_result,
  input logic       int_alloc,
  input logic [7:0] rx_head,
  input logic       int_rcv,
  input logic [7:0] txdone_head,
  input logic       int_txdone,
  input logic [7:0] used_count
);

  p_used_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    used_count <= 8'(PAGES));

  p_alloc_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int_alloc |-> alloc_result < 8'(PAGES));

  p_grant_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_grant && rx_fail));

  p_grant_takes_page_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_grant |-> used_count == $past(used_count) + 8'd1);

  p_host_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |=> !rx_grant && !rx_fail);

  p_rcv_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int_rcv == (rx_head != 8'h80));

  p_txdone_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    int_txdone == (txdone_head != 8'h80));

endmodule

bind pkt_page_mgr pkt_page_mgr_chk #(.PAGES(PAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .rx_grant(rx_grant),
  .rx_fail(rx_fail), .alloc_result(alloc_result), .int_alloc(int_alloc),
  .rx_head(rx_head), .int_rcv(int_rcv), .txdone_head(txdone_head),
  .int_txdone(int_txdone), .used_count(used_count)
);

// File: tb/tb_pkt_page_mgr.sv
`timescale 1ns/100ps
module tb_pkt_page_mgr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic [1:0] host_sel = 2'd0;
  logic [7:0] host_wdata = 8'd0;
  logic       tx_en = 1'b0, auto_rel = 1'b0, rx_req = 1'b0;
  logic       rx_grant, rx_fail;
  logic [1:0] rx_page;
  logic [7:0] alloc_result, pkt_num, txdone_head, rx_head, mem_size, used_count;
  logic       int_alloc, int_rcv, int_txdone, int_txq_empty;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pkt_page_mgr dut (.*);

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rx_pulse();
    @(negedge clk);
    rx_req = 1'b1;
    @(negedge clk);
    rx_req = 1'b0;
  endtask

  task automatic t_reset();
    chk(used_count, 8'd0, "R1 used");
    chk(mem_size, 8'd4, "R1 mem_size");
    chk(alloc_result, 8'd0, "R1 result");
    chk(pkt_num, 8'd0, "R1 pkt_num");
    chk(rx_head, 8'h80, "R1 rx_head");
    chk(txdone_head, 8'h80, "R1 txdone_head");
    chk({4'd0, int_alloc, int_rcv, int_txdone, int_txq_empty}, 8'h01, "R1 flags");
  endtask

  task automatic t_alloc();
    for (int i = 0; i < 4; i++) begin
      wr(2'd0, 8'h20);
      chk(alloc_result, 8'(i), "R3 lowest page");
      chk(8'(int_alloc), 8'd1, "R3 int_alloc");
    end
    wr(2'd0, 8'h20);
    chk(alloc_result, 8'h80, "R3 full result");
    chk(8'(int_alloc), 8'd0, "R3 full int_alloc");
    chk(used_count, 8'd4, "R12 used full");
    wr(2'd1, 8'd2);
    chk(pkt_num, 8'd2, "R2 pkt_num");
    wr(2'd0, 8'hA0);
    chk(alloc_result, 8'd2, "R4 retry on release R8");
    chk(8'(int_alloc), 8'd1, "R4 int_alloc");
    chk(used_count, 8'd4, "R4 used");
    wr(2'd2, 8'h08);
    chk(8'(int_alloc), 8'd0, "R2 ack alloc");
    wr(2'd3, 8'hFF);
    chk(used_count, 8'd4, "R2 sel3 used");
    chk(alloc_result, 8'd2, "R2 sel3 result");
    chk(pkt_num, 8'd2, "R2 sel3 pkt_num");
    rx_pulse();
    chk({6'd0, rx_fail, rx_grant}, 8'h02, "R10 refuse when full");
  endtask

  task automatic t_rxq();
    wr(2'd0, 8'h40);
    chk(used_count, 8'd0, "R5 used");
    chk(alloc_result, 8'd0, "R5 result");
    rx_pulse();
    chk({6'd0, rx_fail, rx_grant}, 8'h01, "R10 grant");
    chk(8'(rx_page), 8'd0, "R10 page0");
    chk(8'(int_rcv), 8'd1, "R10 int_rcv");
    rx_pulse();
    chk(8'(rx_page), 8'd1, "R10 page1");
    wr(2'd0, 8'h20);
    chk(alloc_result, 8'd2, "R3 after rx");
    wr(2'd0, 8'h60);
    chk(rx_head, 8'd1, "R7 head after pop");
    chk(8'(int_rcv), 8'd1, "R7 int_rcv kept");
    chk(used_count, 8'd3, "R7 pop keeps page");
    wr(2'd0, 8'h80);
    chk(rx_head, 8'h80, "R7 empty head");
    chk(8'(int_rcv), 8'd0, "R7 int_rcv cleared");
    chk(used_count, 8'd2, "R7 release");
    wr(2'd0, 8'h20);
    chk(alloc_result, 8'd1, "R3 reuse freed page");
    wr(2'd0, 8'h80);
    chk(used_count, 8'd3, "R7 empty pop no effect");
    wr(2'd0, 8'h40);
    chk(used_count, 8'd0, "R5 clear again");
    chk(8'(int_rcv), 8'd0, "R5 int_rcv");
  endtask

  task automatic t_tx();
    wr(2'd0, 8'h20);
    wr(2'd0, 8'h20);
    for (int i = 0; i < 5; i++) begin
      wr(2'd1, 8'((i + 1) % 2));
      wr(2'd0, 8'hC0);
    end
    chk(8'(int_txq_empty), 8'd0, "R9 queue loaded");
    chk(8'(int_txdone), 8'd0, "R9 held while disabled");
    @(negedge clk); tx_en = 1'b1;
    repeat (5) @(negedge clk);
    chk(8'(int_txq_empty), 8'd1, "R9 drained");
    chk(txdone_head, 8'd1, "R9 first done");
    chk(used_count, 8'd2, "R9 pages kept");
    for (int i = 0; i < 4; i++) begin
      wr(2'd2, 8'h02);
      chk(txdone_head, (i == 3) ? 8'h80 : 8'((i + 1) % 2 == 0 ? 1 : 0), "R8 done order and drop");
    end
    chk(8'(int_txdone), 8'd0, "R12 int_txdone empty");
    @(negedge clk); tx_en = 1'b0;
    wr(2'd1, 8'd0);
    wr(2'd0, 8'hC0);
    wr(2'd0, 8'hC0);
    wr(2'd0, 8'hE0);
    chk(8'(int_txq_empty), 8'd1, "R6 queue cleared");
    chk(used_count, 8'd2, "R6 pages kept");
  endtask

  task automatic t_auto();
    wr(2'd0, 8'h40);
    for (int i = 0; i < 5; i++) wr(2'd0, 8'h20);
    chk(alloc_result, 8'h80, "R4 pending");
    @(negedge clk); tx_en = 1'b1; auto_rel = 1'b1;
    wr(2'd1, 8'd3);
    wr(2'd0, 8'hC0);
    @(negedge clk);
    chk(alloc_result, 8'd3, "R4 retry on auto release R9");
    chk(8'(int_alloc), 8'd1, "R9 int_alloc");
    chk(used_count, 8'd4, "R9 used");
    chk(txdone_head, 8'h80, "R9 nothing parked");
    tx_en = 1'b0; auto_rel = 1'b0;
  endtask

  task automatic t_prio();
    wr(2'd0, 8'h40);
    @(negedge clk);
    host_we = 1'b1; host_sel = 2'd1; host_wdata = 8'd0; rx_req = 1'b1;
    @(negedge clk);
    host_we = 1'b0; rx_req = 1'b0;
    chk(8'(rx_grant), 8'd0, "R11 host beats rx");
    chk(used_count, 8'd0, "R11 no page taken");
    wr(2'd0, 8'h20);
    wr(2'd0, 8'hC0);
    @(negedge clk);
    tx_en = 1'b1; rx_req = 1'b1;
    @(negedge clk);
    chk(8'(rx_grant), 8'd0, "R11 drain beats rx");
    chk(8'(int_txdone), 8'd1, "R11 drain ran");
    @(negedge clk);
    rx_req = 1'b0;
    chk(8'(rx_grant), 8'd1, "R11 rx served later");
    chk(8'(rx_page), 8'd1, "R10 next page");
    chk(rx_head, 8'd1, "R12 rx_head");
    tx_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc();
    t_rxq();
    t_tx();
    t_auto();
    t_prio();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule